// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This block arbitrates among a small set of interrupt request lines and answers acknowledge queries with an 8-bit vector naming the winner. Each source carries a writable level (1 to 7, with 0 meaning disabled), a 4-bit priority used to rank sources sharing a level, and a mask bit. Request lines are registered into a snapshot every clock, and arbitration runs combinationally over that snapshot.

Software queries the block over a simple register bus. One address asks for the overall winner across all levels, and seven more ask for the winner confined to a single level. A separate hardware acknowledge port lets the processor present a level and receive the winning vector for that level. Every acknowledge, from either side, records the winner's level and priority in a capture register. When there is no winner, it returns a zero vector and clears that register.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A read of address 0x08 (overall acknowledge) returns VEC_BASE + index of the unmasked pending source with the highest level. Among sources at that level, the one with the largest priority value wins.
- R2: A read of address 0x08+n (n = 1..7) considers only sources configured at level n, and returns VEC_BASE + index of the one with the largest priority value.
- R3: Asserting hw_ack_stb with hw_lvl = n drives hw_vec one clock later with the same result a level-n register read would give. hw_lvl = 0 always yields 0x00.
- R4: Every acknowledge loads the capture register, readable at address 0x02, with {1'b0, level[2:0], priority[3:0]} of the winner. When a hardware acknowledge and a bus acknowledge happen in the same cycle, the hardware result is kept. Other bus accesses leave the capture register unchanged.
- R5: An acknowledge that finds no eligible source returns vector 0x00 and clears the capture register to 0x00.
- R6: Addresses 0x08 to 0x0F are read-only, so writes to them change nothing. After reset, bus_rdata, hw_vec and the capture register read 0x00.
- R7: A source whose mask bit is 1 (mask register at address 0x01, bit i for source i, reset value all ones) never wins. A source configured at level 0 never wins either.
- R8: When two eligible sources share both level and priority, the lower source index wins.
- R9: Read data appears on bus_rdata one clock after the read strobe. A request must be high at the clock edge before the read edge to be seen by that read.
- R10: Source i is configured at address 0x10+i, with level in bits 6:4 and priority in bits 3:0. That register reads back in the same layout, and resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Interrupt request lines, one per source |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after a read |
| hw_ack_stb | input | 1 | Hardware acknowledge strobe |
| hw_lvl | input | 3 | Level being acknowledged by hardware |
| hw_vec | output | 8 | Vector returned for the hardware acknowledge |

## Verification
The bench sweeps every pattern of the eight request lines under two configurations. The first uses distinct level/priority pairs. The second stacks sources on identical level and priority, masks some of them, and parks one at level 0. A design that compared priority before level, scanned indices from the wrong end, let masked or level-0 sources through, or leaked other levels into a per-level query would return a wrong vector somewhere in the sweep.

After every acknowledge, the bench also reads back the capture register. This exposes a latch that is not cleared on an empty result, that packs fields in the wrong place, or that is disturbed by writes to the read-only addresses. A simultaneous hardware and bus acknowledge checks that the hardware result wins the capture register.

// File: rtl/irq_ack_pkg.sv
// Package: shared types, address map and helpers for the interrupt
// acknowledge controller. Assumes an 8-bit data bus and 3-bit levels.
package irq_ack_pkg;

    localparam int LVL_W = 3;
    localparam int PRI_W = 4;

    // Register address map
    localparam int A_MASK  = 'h01;
    localparam int A_CAP   = 'h02;
    localparam int A_ACK   = 'h08;   // overall ack; A_ACK+n is level n
    localparam int A_CFG   = 'h10;   // A_CFG+i is source i configuration

    typedef struct packed {
        logic             found;
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } win_t;

    // Pack a winner into the capture layout: level 6:4, priority 3:0
    function automatic logic [7:0] cap_word(input win_t w);
        return w.found ? {1'b0, w.lvl, w.pri} : 8'h00;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: per-source level/priority configuration and the mask register.
// Assumes the top decodes writes; mask bit set means the source is blocked.
module irq_cfg_regs
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [LVL_W-1:0] src_lvl [NUM_SRC],
    output logic [PRI_W-1:0] src_pri [NUM_SRC],
    output logic [NUM_SRC-1:0] src_mask
);

    // Mask register: all sources blocked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_mask <= '1;
        else if (wr_en && addr == ADDR_W'(A_MASK))
            src_mask <= wdata[NUM_SRC-1:0];
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        // Per-source configuration word: level and priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_lvl[gi] <= '0;
                src_pri[gi] <= '0;
            end else if (wr_en && addr == ADDR_W'(A_CFG + gi)) begin
                src_lvl[gi] <= wdata[6:4];
                src_pri[gi] <= wdata[3:0];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational winner search over the pending snapshot.
// In "any level" mode the rank is {level, priority}; otherwise only
// sources at want_lvl compete on priority. Lower index wins exact ties.
// Assumes inputs come from registers (no reset needed here).
module irq_arbiter
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int KEY_W  = LVL_W + PRI_W
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [LVL_W-1:0]   src_lvl [NUM_SRC],
    input  logic [PRI_W-1:0]   src_pri [NUM_SRC],
    input  logic               any_lvl,
    input  logic [LVL_W-1:0]   want_lvl,
    output win_t               win,
    output logic [IDX_W-1:0]   win_idx
);

    logic [NUM_SRC-1:0] elig;
    logic [KEY_W-1:0]   key [NUM_SRC];
    logic [KEY_W-1:0]   win_key;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_elig
        // Eligibility and rank key of one source
        assign elig[gi] = pend[gi] && !mask[gi] && (src_lvl[gi] != '0) &&
                          (any_lvl || src_lvl[gi] == want_lvl);
        assign key[gi]  = {(any_lvl ? src_lvl[gi] : {LVL_W{1'b0}}), src_pri[gi]};
    end

    // Linear scan from index 0; only a strictly larger key replaces
    always_comb begin
        win     = '0;
        win_idx = '0;
        win_key = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win.found || key[i] > win_key)) begin
                win.found = 1'b1;
                win.lvl   = src_lvl[i];
                win.pri   = src_pri[i];
                win_key   = key[i];
                win_idx   = IDX_W'(i);
            end
        end
    end

    // Checks: winner is eligible, and no eligible source outranks it
    always_comb begin
        if (win.found === 1'b1)
            p_winner_eligible_r7: assert (elig[win_idx]);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] === 1'b1) begin
                p_found_when_eligible_r5: assert (win.found);
                p_no_better_source_r8: assert (key[i] < win_key ||
                    (key[i] == win_key && IDX_W'(i) >= win_idx));
            end
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: top of the interrupt acknowledge controller. Registers the
// request lines, decodes the register bus, runs one arbiter for bus
// queries and one for the hardware acknowledge port, and keeps the
// level/priority capture register. Assumes NUM_SRC between 2 and 8.
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int ADDR_W   = 6,
    parameter int VEC_BASE = 64,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               hw_ack_stb,
    input  logic [2:0]         hw_lvl,
    output logic [7:0]         hw_vec
);

    localparam logic [7:0] VBASE = 8'(VEC_BASE);

    logic [NUM_SRC-1:0] pend_q;
    logic [LVL_W-1:0]   src_lvl [NUM_SRC];
    logic [PRI_W-1:0]   src_pri [NUM_SRC];
    logic [NUM_SRC-1:0] src_mask;
    logic               rd_en, wr_en, is_ack, ack_rd;
    win_t               bus_win, hw_win;
    logic [IDX_W-1:0]   bus_idx, hw_idx;
    logic [7:0]         bus_vec, hw_vec_d, rd_mux, cap_q;

    // Snapshot of the request lines used by both arbiters
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_req;
    end

    // Bus decode: acknowledge window is 0x08..0x0F
    assign rd_en  = bus_sel && !bus_wr;
    assign wr_en  = bus_sel && bus_wr;
    assign is_ack = (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(A_ACK >> 3));
    assign ack_rd = rd_en && is_ack;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .src_lvl(src_lvl), .src_pri(src_pri),
        .src_mask(src_mask)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_bus_arb (
        .pend(pend_q), .mask(src_mask), .src_lvl(src_lvl), .src_pri(src_pri),
        .any_lvl(bus_addr[2:0] == 3'd0), .want_lvl(bus_addr[2:0]),
        .win(bus_win), .win_idx(bus_idx)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_hw_arb (
        .pend(pend_q), .mask(src_mask), .src_lvl(src_lvl), .src_pri(src_pri),
        .any_lvl(1'b0), .want_lvl(hw_lvl),
        .win(hw_win), .win_idx(hw_idx)
    );

    // Vector generation: base plus index, zero when nothing wins
    assign bus_vec  = bus_win.found ? VBASE + 8'(bus_idx) : 8'h00;
    assign hw_vec_d = hw_win.found  ? VBASE + 8'(hw_idx)  : 8'h00;

    // Read multiplexer across the register map
    always_comb begin
        rd_mux = '0;
        if (is_ack)
            rd_mux = bus_vec;
        else if (bus_addr == ADDR_W'(A_MASK))
            rd_mux[NUM_SRC-1:0] = src_mask;
        else if (bus_addr == ADDR_W'(A_CAP))
            rd_mux = cap_q;
        for (int i = 0; i < NUM_SRC; i++)
            if (bus_addr == ADDR_W'(A_CFG + i))
                rd_mux = {1'b0, src_lvl[i], src_pri[i]};
    end

    // Registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    // Hardware acknowledge result register
    always_ff @(posedge clk) begin
        if (!rst_n)          hw_vec <= '0;
        else if (hw_ack_stb) hw_vec <= hw_vec_d;
    end

    // Capture register: hardware acknowledge takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n)          cap_q <= '0;
        else if (hw_ack_stb) cap_q <= cap_word(hw_win);
        else if (ack_rd)     cap_q <= cap_word(bus_win);
    end

    // Empty bus acknowledge leaves a zero capture, a hit leaves nonzero
    p_empty_clears_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !hw_ack_stb) |=> ((bus_rdata == 8'h00) == (cap_q == 8'h00)));

    // Writes into the acknowledge window leave the capture untouched
    p_ack_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ack && !hw_ack_stb) |=> $stable(cap_q));

    // Capture only moves on an acknowledge
    p_cap_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_ack_stb && !ack_rd) |=> $stable(cap_q));

    // Per-level bus read captures a winner of that level only
    p_level_read_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && bus_addr[2:0] != 3'd0 && !hw_ack_stb) |=>
        (cap_q == 8'h00 || cap_q[6:4] == $past(bus_addr[2:0])));

    // Hardware acknowledge returns zero or a vector in the source range
    p_hw_vec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack_stb |=> (hw_vec == 8'h00 ||
        (hw_vec >= VBASE && hw_vec < VBASE + 8'(NUM_SRC))));

    // Hardware acknowledge captures a winner of the presented level
    p_hw_cap_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack_stb |=> (cap_q == 8'h00 || cap_q[6:4] == $past(hw_lvl)));

endmodule

// File: tb/irq_ack_ctrl_test.sv
// Bench: sweeps all request patterns over two configurations, checking
// every acknowledge path and the capture register against a model.
module irq_ack_ctrl_test;

    localparam int N = 8;
    localparam int VB = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         hw_ack_stb = 1'b0;
    logic [2:0]   hw_lvl = '0;
    logic [7:0]   hw_vec;

    int n_chk = 0, n_bad = 0;
    int m_lvl [N];
    int m_pri [N];
    logic [N-1:0] m_mask;

    always #4 clk = ~clk;   // 125 MHz

    irq_ack_ctrl #(.NUM_SRC(N), .ADDR_W(6), .VEC_BASE(VB)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_ack_stb(hw_ack_stb), .hw_lvl(hw_lvl),
        .hw_vec(hw_vec)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // Model: search levels high to low, priorities high to low, index low to high
    task automatic model(input logic [N-1:0] p, input bit any, input int want,
                         output logic [7:0] vec, output logic [7:0] cap);
        vec = 8'h00; cap = 8'h00;
        for (int l = 7; l >= 1; l--) begin
            if (!any && l != want) continue;
            for (int q = 15; q >= 0; q--)
                for (int i = 0; i < N; i++)
                    if (vec == 8'h00 && p[i] && !m_mask[i] && m_lvl[i] == l && m_pri[i] == q) begin
                        vec = 8'(VB + i);
                        cap = 8'((l << 4) | q);
                    end
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic hw_ack(input logic [2:0] l, output logic [7:0] v);
        hw_ack_stb = 1'b1; hw_lvl = l;
        @(posedge clk); @(negedge clk);
        v = hw_vec;
        hw_ack_stb = 1'b0;
    endtask

    task automatic set_irq(input logic [N-1:0] p);
        irq_req = p;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic configure(input int lv [N], input int pr [N], input logic [N-1:0] mk);
        logic [7:0] rb;
        for (int i = 0; i < N; i++) begin
            m_lvl[i] = lv[i]; m_pri[i] = pr[i];
            bus_write(6'(16 + i), 8'((lv[i] << 4) | pr[i]));
            bus_read(6'(16 + i), rb);
            chk("R10 config readback", rb, 8'((lv[i] << 4) | pr[i]));
        end
        m_mask = mk;
        bus_write(6'h01, mk);
    endtask

    task automatic sweep();
        logic [7:0] v, c, ev, ec;
        for (int p = 0; p < (1 << N); p++) begin
            set_irq(N'(p));
            model(N'(p), 1'b1, 0, ev, ec);
            bus_read(6'h08, v);
            chk("R1 overall ack vector", v, ev);
            bus_read(6'h02, c);
            chk("R5 capture after overall ack", c, ec);
            for (int l = 1; l <= 7; l++) begin
                model(N'(p), 1'b0, l, ev, ec);
                bus_read(6'(8 + l), v);
                chk("R2 level ack vector", v, ev);
                bus_read(6'h02, c);
                chk("R4 capture after level ack", c, ec);
            end
            for (int l = 0; l <= 7; l++) begin
                model(N'(p), 1'b0, l, ev, ec);
                hw_ack(3'(l), v);
                chk("R3 hardware ack vector", v, ev);
                bus_read(6'h02, c);
                chk("R4 capture after hardware ack", c, ec);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, c, ev, ec;
        int lvA [N] = '{1, 1, 2, 2, 3, 3, 4, 4};
        int prA [N] = '{0, 5, 10, 15, 4, 9, 14, 3};
        int lvB [N] = '{3, 7, 3, 7, 3, 0, 3, 7};
        int prB [N] = '{6, 6, 6, 9, 6, 6, 2, 9};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 reset values
        chk("R6 reset rdata", bus_rdata, 8'h00);
        chk("R6 reset hw_vec", hw_vec, 8'h00);
        bus_read(6'h02, c);
        chk("R6 reset capture", c, 8'h00);
        bus_read(6'h01, c);
        chk("R7 reset mask all ones", c, 8'hFF);
        bus_read(6'h13, c);
        chk("R10 reset config", c, 8'h00);

        // R7 everything masked out of reset: no winner
        set_irq('1);
        bus_read(6'h08, v);
        chk("R7 masked sources ignored", v, 8'h00);

        configure(lvA, prA, 8'h00);
        sweep();

        // R6 writes to acknowledge window change nothing
        set_irq(8'h30);
        bus_read(6'h08, v);
        bus_read(6'h02, c);
        chk("R1 ack before readonly test", v, 8'h45);
        bus_write(6'h08, 8'hFF);
        bus_write(6'h0B, 8'h00);
        bus_read(6'h02, ec);
        chk("R6 capture unchanged by ack writes", ec, c);
        bus_read(6'h08, v);
        chk("R6 ack vector unchanged by writes", v, 8'h45);

        // R4 simultaneous hardware and bus acknowledge: hardware wins capture
        set_irq(8'h0F);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h08;
        hw_ack_stb = 1'b1; hw_lvl = 3'd1;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; hw_ack_stb = 1'b0;
        chk("R1 simultaneous bus vector", bus_rdata, 8'h43);
        chk("R3 simultaneous hw vector", hw_vec, 8'h41);
        bus_read(6'h02, c);
        chk("R4 hardware result kept in capture", c, 8'h15);

        // R5 empty acknowledge clears capture
        set_irq(8'h00);
        bus_read(6'h08, v);
        chk("R5 empty ack vector", v, 8'h00);
        bus_read(6'h02, c);
        chk("R5 empty ack clears capture", c, 8'h00);

        // R9 request raised right before the read is not yet visible
        irq_req = 8'h01;
        bus_read(6'h08, v);
        chk("R9 snapshot one clock behind", v, 8'h00);
        bus_read(6'h08, v);
        chk("R9 request visible after snapshot", v, 8'h40);

        configure(lvB, prB, 8'h05);
        sweep();

        // R8 tie: sources 3 and 7 equal at level 7 priority 9
        set_irq(8'h88);
        bus_read(6'h08, v);
        chk("R8 tie goes to lower index", v, 8'h43);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule